// File: doc/BRIEF.md
# ADC Start Trigger Selector

This block turns the event strobes of a motor-control timer pair into two independent start pulses for analog-to-digital converters. Four single-cycle event strobes come in: counter underflow, cycle (period) match, and two compare matches from a companion timer. Each output channel has its own 4-bit source-select field. It ORs every selected source into one registered start pulse.

The underflow and cycle-match events are thinned first. A shared programmable ratio lets only every Nth event of each kind through. The thinned event then reaches a channel only while its interrupt output enable is set. Each channel has a 2-bit direction mask for the companion compare events. For each compare source, the mask bit chooses whether that source counts while the 16-bit counter runs up or while it runs down. The flag that reports the count direction is read in the same cycle as the compare strobe.

Top module: `adc_trig_sel`

## Requirements
- R1: Each trigger output is registered. It is high for exactly one cycle, in the clock cycle after a qualifying event. Several qualifying events in the same cycle still give one single-cycle pulse.
- R2: Select-field bit positions are: bit 0 underflow, bit 1 cycle match, bit 2 compare 0, bit 3 compare 1. Every selected source is ORed into the channel output. A source whose bit is 0 has no effect on that output.
- R3: A thinned underflow event reaches a channel only while `unf_irq_en` is 1. A thinned cycle-match event reaches a channel only while `cyc_irq_en` is 1.
- R4: A ratio value k on `cull_ratio` gives N = k+1 (N from 1 to 8). For each of underflow and cycle match, separately, events 1 to N-1 are dropped and the Nth passes, and then the count restarts. Events are counted whatever the enables and selects are.
- R5: A cycle with `cull_wr` high loads `cull_ratio` and clears both thinning counters. An underflow or cycle-match event in that same cycle is neither counted nor passed.
- R6: With a channel's mask bit at 0, the matching compare event qualifies only when `cnt_down` is 0 (up-counting) in the cycle of the strobe.
- R7: With a channel's mask bit at 1, the matching compare event qualifies only when `cnt_down` is 1 (down-counting) in the cycle of the strobe.
- R8: Mask bit 0 of a channel governs compare 0 and mask bit 1 governs compare 1. The two channels are independent, each with its own select and mask.
- R9: While reset is asserted the outputs are low. After reset the ratio is N=1 and both thinning counters are cleared, so the first enabled underflow passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_unf | input | 1 | Counter underflow strobe |
| ev_cyc | input | 1 | Cycle match strobe |
| ev_cmp0 | input | 1 | Companion compare 0 strobe |
| ev_cmp1 | input | 1 | Companion compare 1 strobe |
| cnt_down | input | 1 | Count direction, 0 up, 1 down |
| unf_irq_en | input | 1 | Underflow interrupt output enable |
| cyc_irq_en | input | 1 | Cycle interrupt output enable |
| cull_wr | input | 1 | Load ratio and clear thinning counters |
| cull_ratio | input | 3 | Thinning ratio minus one |
| sel_a | input | 4 | Source select, channel A |
| sel_b | input | 4 | Source select, channel B |
| dmask_a | input | 2 | Direction mask, channel A |
| dmask_b | input | 2 | Direction mask, channel B |
| trig_a | output | 1 | Start pulse, channel A |
| trig_b | output | 1 | Start pulse, channel B |

## Verification
The properties assume that every event input is a strobe sampled once per clock. They also assume that the select, mask and enable inputs are plain levels that may change in any cycle. The strobes and the direction flag can take any value in the same cycle, and no ordering between them is required. The random stimulus draws all inputs afresh each cycle and fires `cull_wr` only occasionally, so the thinning counters often get the chance to reach their ratio.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int SRC_N = 4;
  localparam int SRC_UNF = 0;
  localparam int SRC_CYC = 1;
  localparam int SRC_CMP0 = 2;
  localparam int SRC_CMP1 = 3;

  function automatic logic cull_hit(input logic [2:0] cnt, input logic [2:0] ratio);
    return cnt == ratio;
  endfunction

  function automatic logic [2:0] cull_next(input logic [2:0] cnt, input logic [2:0] ratio);
    return (cnt == ratio) ? 3'd0 : cnt + 3'd1;
  endfunction

  function automatic logic dir_ok(input logic down, input logic mask);
    return down == mask;
  endfunction
endpackage

// File: rtl/adc_trig_cull.sv
module adc_trig_cull #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev,
  input  logic             clr,
  input  logic [CNT_W-1:0] ratio,
  output logic             pass
);
  import adc_trig_pkg::*;
  logic [CNT_W-1:0] cnt_q;

  assign pass = ev && !clr && cull_hit(cnt_q, ratio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (ev)     cnt_q <= cull_next(cnt_q, ratio);
  end
endmodule

// File: rtl/adc_trig_chan.sv
module adc_trig_chan
  import adc_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] sel,
  input  logic [1:0]       dmask,
  input  logic             q_unf,
  input  logic             q_cyc,
  input  logic [1:0]       ev_cmp,
  input  logic             cnt_down,
  output logic             trig
);
  logic [SRC_N-1:0] src_ok;
  logic             fire;

  assign src_ok[SRC_UNF] = q_unf;
  assign src_ok[SRC_CYC] = q_cyc;

  for (genvar c = 0; c < 2; c++) begin : g_cmp
    assign src_ok[SRC_CMP0 + c] = ev_cmp[c] && dir_ok(cnt_down, dmask[c]);
  end

  assign fire = |(sel & src_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig <= 1'b0;
    else        trig <= fire;
  end
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_trig_pkg::*;
#(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_unf,
  input  logic               ev_cyc,
  input  logic               ev_cmp0,
  input  logic               ev_cmp1,
  input  logic               cnt_down,
  input  logic               unf_irq_en,
  input  logic               cyc_irq_en,
  input  logic               cull_wr,
  input  logic [RATIO_W-1:0] cull_ratio,
  input  logic [SRC_N-1:0]   sel_a,
  input  logic [SRC_N-1:0]   sel_b,
  input  logic [1:0]         dmask_a,
  input  logic [1:0]         dmask_b,
  output logic               trig_a,
  output logic               trig_b
);
  localparam int CH_N = 2;

  logic [RATIO_W-1:0] ratio_q;
  logic               pass_unf, pass_cyc;
  logic               q_unf, q_cyc;
  logic [SRC_N-1:0]   sel_arr   [CH_N];
  logic [1:0]         dmask_arr [CH_N];
  logic [CH_N-1:0]    trig_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ratio_q <= '0;
    else if (cull_wr) ratio_q <= cull_ratio;
  end

  adc_trig_cull #(.CNT_W(RATIO_W)) u_cull_unf (
    .clk(clk), .rst_n(rst_n), .ev(ev_unf), .clr(cull_wr), .ratio(ratio_q), .pass(pass_unf)
  );
  adc_trig_cull #(.CNT_W(RATIO_W)) u_cull_cyc (
    .clk(clk), .rst_n(rst_n), .ev(ev_cyc), .clr(cull_wr), .ratio(ratio_q), .pass(pass_cyc)
  );

  assign q_unf = pass_unf && unf_irq_en;
  assign q_cyc = pass_cyc && cyc_irq_en;

  assign sel_arr[0]   = sel_a;
  assign sel_arr[1]   = sel_b;
  assign dmask_arr[0] = dmask_a;
  assign dmask_arr[1] = dmask_b;

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    adc_trig_chan u_chan (
      .clk(clk), .rst_n(rst_n), .sel(sel_arr[ch]), .dmask(dmask_arr[ch]),
      .q_unf(q_unf), .q_cyc(q_cyc), .ev_cmp({ev_cmp1, ev_cmp0}),
      .cnt_down(cnt_down), .trig(trig_vec[ch])
    );
  end

  assign trig_a = trig_vec[0];
  assign trig_b = trig_vec[1];
endmodule

// File: rtl/adc_trig_chk.sv
module adc_trig_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_unf,
  input logic       ev_cyc,
  input logic       ev_cmp0,
  input logic       ev_cmp1,
  input logic       cnt_down,
  input logic       unf_irq_en,
  input logic       cull_wr,
  input logic [3:0] sel_a,
  input logic [3:0] sel_b,
  input logic [1:0] dmask_b,
  input logic [2:0] ratio_q,
  input logic       pass_unf,
  input logic       pass_cyc,
  input logic       trig_a,
  input logic       trig_b
);
  assert_pulse_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_a |-> $past(ev_unf || ev_cyc || ev_cmp0 || ev_cmp1));

  assert_no_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_a == 4'b0000) |-> !trig_a);

  assert_unf_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_a && $past(sel_a == 4'b0001)) |-> $past(unf_irq_en && ev_unf));

  assert_pass_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pass_unf |-> ev_unf);

  assert_ratio_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q == 3'd0 && ev_unf && !cull_wr) |-> pass_unf);

  assert_write_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cull_wr |-> (!pass_unf && !pass_cyc));

  assert_dir_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_b && $past(sel_b == 4'b0100) && $past(dmask_b[0] == 1'b0)) |-> $past(!cnt_down));

  assert_dir_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_b && $past(sel_b == 4'b1000) && $past(dmask_b[1] == 1'b1)) |-> $past(cnt_down));

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!trig_a && !trig_b));
endmodule

bind adc_trig_sel adc_trig_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_unf(ev_unf), .ev_cyc(ev_cyc), .ev_cmp0(ev_cmp0),
  .ev_cmp1(ev_cmp1), .cnt_down(cnt_down), .unf_irq_en(unf_irq_en), .cull_wr(cull_wr),
  .sel_a(sel_a), .sel_b(sel_b), .dmask_b(dmask_b), .ratio_q(ratio_q),
  .pass_unf(pass_unf), .pass_cyc(pass_cyc), .trig_a(trig_a), .trig_b(trig_b)
);

// File: tb/tb_adc_trig_sel.sv
`timescale 1ns/1ps
module tb_adc_trig_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_unf = 0, ev_cyc = 0, ev_cmp0 = 0, ev_cmp1 = 0, cnt_down = 0;
  logic unf_irq_en = 0, cyc_irq_en = 0, cull_wr = 0;
  logic [2:0] cull_ratio = 0;
  logic [3:0] sel_a = 0, sel_b = 0;
  logic [1:0] dmask_a = 0, dmask_b = 0;
  logic trig_a, trig_b;

  int checks = 0, failures = 0;
  int m_cu = 0, m_cc = 0, m_r = 0;
  logic exp_a = 0, exp_b = 0;
  int pulses_a = 0, pulses_b = 0;
  string cur_req = "R1 R2";

  always #2.5 clk = ~clk;

  adc_trig_sel dut (
    .clk(clk), .rst_n(rst_n), .ev_unf(ev_unf), .ev_cyc(ev_cyc), .ev_cmp0(ev_cmp0),
    .ev_cmp1(ev_cmp1), .cnt_down(cnt_down), .unf_irq_en(unf_irq_en), .cyc_irq_en(cyc_irq_en),
    .cull_wr(cull_wr), .cull_ratio(cull_ratio), .sel_a(sel_a), .sel_b(sel_b),
    .dmask_a(dmask_a), .dmask_b(dmask_b), .trig_a(trig_a), .trig_b(trig_b)
  );

  function automatic logic chan_model(input logic [3:0] s, input logic [1:0] m,
                                      input logic qu, input logic qc);
    logic hit = 1'b0;
    if (s[0] && qu) hit = 1'b1;
    if (s[1] && qc) hit = 1'b1;
    if (s[2] && ev_cmp0 && (m[0] ? cnt_down : !cnt_down)) hit = 1'b1;
    if (s[3] && ev_cmp1 && (m[1] ? cnt_down : !cnt_down)) hit = 1'b1;
    return hit;
  endfunction

  task automatic check(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // inputs are already set; model one clock, then compare after the edge
  task automatic tick();
    logic pu, pc;
    pu = ev_unf && !cull_wr && (m_cu == m_r);
    pc = ev_cyc && !cull_wr && (m_cc == m_r);
    exp_a = chan_model(sel_a, dmask_a, pu && unf_irq_en, pc && cyc_irq_en);
    exp_b = chan_model(sel_b, dmask_b, pu && unf_irq_en, pc && cyc_irq_en);
    if (cull_wr) begin
      m_cu = 0; m_cc = 0; m_r = int'(cull_ratio);
    end else begin
      if (ev_unf) m_cu = (m_cu == m_r) ? 0 : m_cu + 1;
      if (ev_cyc) m_cc = (m_cc == m_r) ? 0 : m_cc + 1;
    end
    @(posedge clk);
    @(negedge clk);
    check({cur_req, " chA"}, trig_a, exp_a);
    check({cur_req, " chB"}, trig_b, exp_b);
    if (trig_a) pulses_a++;
    if (trig_b) pulses_b++;
  endtask

  task automatic idle();
    ev_unf = 0; ev_cyc = 0; ev_cmp0 = 0; ev_cmp1 = 0; cull_wr = 0;
    tick();
  endtask

  task automatic clear_cfg();
    sel_a = 0; sel_b = 0; dmask_a = 0; dmask_b = 0;
    unf_irq_en = 0; cyc_irq_en = 0;
    idle();
    pulses_a = 0; pulses_b = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R9: quiet during reset, default ratio N=1 afterwards
    repeat (3) @(negedge clk);
    check("R9 reset chA", trig_a, 1'b0);
    check("R9 reset chB", trig_b, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R9";
    sel_a = 4'b0001; unf_irq_en = 1; ev_unf = 1;
    tick();
    check("R9 first underflow passes", trig_a, 1'b1);
    clear_cfg();

    // R4: ratio 2 -> N=3, six underflows give two pulses
    cur_req = "R4";
    cull_wr = 1; cull_ratio = 3'd2; tick(); cull_wr = 0;
    sel_a = 4'b0001; unf_irq_en = 1;
    for (int i = 0; i < 6; i++) begin ev_unf = 1; tick(); idle(); end
    check_int("R4 pulses with N=3", pulses_a, 2);
    clear_cfg();

    // R5: write clears count; event in the write cycle is discarded
    cur_req = "R5";
    sel_b = 4'b0010; cyc_irq_en = 1;
    for (int i = 0; i < 2; i++) begin ev_cyc = 1; tick(); end
    ev_cyc = 1; cull_wr = 1; cull_ratio = 3'd2; tick(); cull_wr = 0;
    for (int i = 0; i < 3; i++) begin ev_cyc = 1; tick(); end
    idle();
    check_int("R5 pulses after rewrite", pulses_b, 1);
    clear_cfg();
    cull_wr = 1; cull_ratio = 3'd0; tick(); cull_wr = 0;

    // R3: enables off block thinned sources
    cur_req = "R3";
    sel_a = 4'b0011; sel_b = 4'b0011;
    for (int i = 0; i < 4; i++) begin ev_unf = 1; ev_cyc = 1; tick(); end
    idle();
    check_int("R3 no pulse with enables low", pulses_a + pulses_b, 0);
    clear_cfg();

    // R6 / R7: direction masks on compare 0
    cur_req = "R6";
    sel_b = 4'b0100; dmask_b = 2'b00;
    ev_cmp0 = 1; cnt_down = 1; tick();
    ev_cmp0 = 1; cnt_down = 0; tick(); idle();
    check_int("R6 up-only pulses", pulses_b, 1);
    clear_cfg();
    cur_req = "R7";
    sel_b = 4'b0100; dmask_b = 2'b01;
    ev_cmp0 = 1; cnt_down = 0; tick();
    ev_cmp0 = 1; cnt_down = 1; tick(); idle();
    check_int("R7 down-only pulses", pulses_b, 1);
    clear_cfg();

    // R8: compare 1 uses mask bit 1; channels independent
    cur_req = "R8";
    sel_a = 4'b1000; dmask_a = 2'b10; sel_b = 4'b1000; dmask_b = 2'b00;
    ev_cmp1 = 1; cnt_down = 1; tick(); idle();
    check_int("R8 chA pulses", pulses_a, 1);
    check_int("R8 chB pulses", pulses_b, 0);
    clear_cfg();

    // R1 / R2: coincident sources give one single-cycle pulse
    cur_req = "R1";
    sel_a = 4'b1111; dmask_a = 2'b00; unf_irq_en = 1; cyc_irq_en = 1; cnt_down = 0;
    ev_unf = 1; ev_cyc = 1; ev_cmp0 = 1; ev_cmp1 = 1; tick();
    idle();
    check_int("R1 one pulse for coincident events", pulses_a, 1);
    check("R1 pulse ends", trig_a, 1'b0);
    clear_cfg();

    // random mix
    cur_req = "R2 R4";
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      ev_unf = ($urandom % 3) == 0; ev_cyc = ($urandom % 3) == 0;
      ev_cmp0 = ($urandom % 4) == 0; ev_cmp1 = ($urandom % 4) == 0;
      cnt_down = $urandom; unf_irq_en = ($urandom % 4) != 0; cyc_irq_en = ($urandom % 4) != 0;
      cull_wr = ($urandom % 40) == 0; cull_ratio = $urandom;
      sel_a = $urandom; sel_b = $urandom; dmask_a = $urandom; dmask_b = $urandom;
      tick();
    end
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule